// File: doc/BRIEF.md
# Jeffress Interaural Delay Localizer

This block estimates the arrival-time difference of one echo at two receivers. The time difference is mapped to a row of coincidence modules. A spike strobe from the left receiver and a spike strobe from the right receiver each enter their own chain of programmable delay stages. The two chains run in opposite directions along the row. Module `i` sees the left pulse after the summed delay of left stages `0..i`. It sees the right pulse after the summed delay of right stages `i..N_CD-1`. So every module is tuned to one particular difference between the two channels. Each module measures the gap, in microsecond ticks, between its two arrivals. It holds three coincidence elements, each with its own window, and reports a hit when at least two of them accept the gap. After both chains drain, a sequential scan picks the hitting module with the smallest gap, and that module's index is the azimuth bin.

All delays and windows are counted in ticks. A prescaler derives one tick every `TICK_DIV` clocks. Delay stage values and the three window widths live in a small register file that is written through a single write port. The block has no activity between operations. One operation takes one spike pair, at a rate of up to about a hundred per second.

The controller has five states: `ST_IDLE`, `ST_ARMED`, `ST_TRAVEL`, `ST_SCAN` and `ST_REPORT`. Its transitions are:
- idle to armed on a spike from one channel;
- idle to travel when both channels spike in the same cycle;
- armed to travel when the second channel spikes;
- armed to report when the activation window runs out;
- travel to scan when both chains are empty;
- scan to report after the last module;
- report to idle, always.

Top module: `itd_localizer`

## Requirements
- R1: After reset, `loc_valid`, `no_det` and `loc_idx` are all 0, and they stay 0 while no spike arrives.
- R2: A spike enters its chain on the first tick after it was accepted. Each stage holds the pulse for its programmed number of ticks. The left pulse reaches module `i` after the sum of left delays `0..i`. The right pulse reaches it after the sum of right delays `i..N_CD-1`.
- R3: A written tap delay is clamped into `[DLY_MIN, DLY_MAX]`. A written window width is clamped to at most `CDW_MAX`.
- R4: A coincidence element fires when the gap between the two arrivals at its module is at most its window width, whichever side arrives first.
- R5: A module hits only when at least two of its three elements fire. In effect, the gap must be at most the median of the three windows.
- R6: Among hitting modules, the one with the smallest gap wins. On a tie, the lowest index wins.
- R7: The second spike is accepted while fewer than `WIN_TICKS` ticks have passed since the first. If the window runs out first, `no_det` pulses for one cycle and the block returns to idle.
- R8: When both spikes were accepted but no module hits, `no_det` pulses instead of `loc_valid`.
- R9: Each operation ends with exactly one single-cycle pulse on either `loc_valid` or `no_det`. `loc_idx` carries the winner in that cycle.
- R10: Spikes in travel, scan or report are ignored. A repeated spike on the channel already accepted in the armed state is also ignored.
- R11: Spikes on both channels in the same cycle count as a zero time difference.
- R12: The write port decodes `cfg_tgt` as follows: 0 sets left stage `cfg_addr`, 1 sets right stage `cfg_addr`, and 2 sets window element `cfg_addr` (0..2). Value 3, and window addresses above 2, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spk_l | input | 1 | Left receiver spike strobe, one cycle |
| spk_r | input | 1 | Right receiver spike strobe, one cycle |
| cfg_we | input | 1 | Write enable for the delay and window file |
| cfg_tgt | input | 2 | Write target: 0 left stage, 1 right stage, 2 window, 3 none |
| cfg_addr | input | AW | Stage index or window element |
| cfg_data | input | XW | Value to write, in ticks |
| loc_valid | output | 1 | One-cycle pulse: a winning module was found |
| loc_idx | output | IW | Winning module index, valid with `loc_valid` |
| no_det | output | 1 | One-cycle pulse: no detection |

## Verification
The bench builds the block with eight modules, two clocks per tick, stage delays of 2 to 12 ticks, a 12-tick activation window and windows up to 15 ticks. With these values the full path of either chain is at most 96 ticks, so every operation, including the window timeout, finishes in a few hundred cycles. The short values also let random time differences across the whole ±11-tick acceptance range land on coincidences, near misses, ties and clamped delays. Directed cases with uniform delays place exact ties, single-tick gaps and majority splits between neighbouring modules.

// File: rtl/itd_pkg.sv
package itd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_TRAVEL = 3'd2,
        ST_SCAN   = 3'd3,
        ST_REPORT = 3'd4
    } itd_state_e;

    localparam logic [1:0] TGT_LEFT  = 2'd0;
    localparam logic [1:0] TGT_RIGHT = 2'd1;
    localparam logic [1:0] TGT_WIN   = 2'd2;
    localparam logic [1:0] TGT_NONE  = 2'd3;

    localparam int N_ELEM = 3;

endpackage

// File: rtl/itd_cfg_regs.sv
module itd_cfg_regs
    import itd_pkg::*;
#(
    parameter int N        = 40,
    parameter int DW       = 9,
    parameter int CW       = 6,
    parameter int XW       = 9,
    parameter int AW       = 6,
    parameter int DLY_MIN  = 10,
    parameter int DLY_MAX  = 300,
    parameter int CDW_MAX  = 63,
    parameter int CDW_INIT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [1:0]                 tgt,
    input  logic [AW-1:0]              addr,
    input  logic [XW-1:0]              data,
    output logic [N-1:0][DW-1:0]       dly_l,
    output logic [N-1:0][DW-1:0]       dly_r,
    output logic [N_ELEM-1:0][CW-1:0]  win
);

    function automatic logic [DW-1:0] clamp_dly(input logic [XW-1:0] v);
        if (v < XW'(DLY_MIN))      return DW'(DLY_MIN);
        else if (v > XW'(DLY_MAX)) return DW'(DLY_MAX);
        else                       return DW'(v);
    endfunction

    function automatic logic [CW-1:0] clamp_win(input logic [XW-1:0] v);
        if (v > XW'(CDW_MAX)) return CW'(CDW_MAX);
        else                  return CW'(v);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                dly_l[k] <= DW'(DLY_MIN);
                dly_r[k] <= DW'(DLY_MIN);
            end
            for (int j = 0; j < N_ELEM; j++) begin
                win[j] <= CW'(CDW_INIT);
            end
        end else if (we) begin
            for (int k = 0; k < N; k++) begin
                if (addr == AW'(k)) begin
                    if (tgt == TGT_LEFT)  dly_l[k] <= clamp_dly(data);
                    if (tgt == TGT_RIGHT) dly_r[k] <= clamp_dly(data);
                end
            end
            for (int j = 0; j < N_ELEM; j++) begin
                if (tgt == TGT_WIN && addr == AW'(j)) win[j] <= clamp_win(data);
            end
        end
    end

    AST_NONE_TARGET_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && tgt == TGT_NONE) |=> ($stable(dly_l) && $stable(dly_r) && $stable(win))); // R12

    for (genvar k = 0; k < N; k++) begin : g_rng
        AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (dly_l[k] >= DW'(DLY_MIN)) && (dly_r[k] >= DW'(DLY_MIN))); // R3
    end

endmodule

// File: rtl/itd_tap_stage.sv
module itd_tap_stage #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] dly,
    output logic          busy,
    output logic          emit
);

    logic [DW-1:0] cnt_q;

    assign emit = tick && busy && (cnt_q == DW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            cnt_q <= dly;
        end else if (emit) begin
            busy  <= 1'b0;
        end else if (tick && busy) begin
            cnt_q <= cnt_q - DW'(1);
        end
    end

    AST_LOAD_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n || clr)
        load |-> !busy); // R2

endmodule

// File: rtl/itd_cd_module.sv
module itd_cd_module
    import itd_pkg::*;
#(
    parameter int CW = 6,
    parameter int GW = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      tick,
    input  logic                      arr_l,
    input  logic                      arr_r,
    input  logic [N_ELEM-1:0][CW-1:0] win,
    output logic                      hit,
    output logic [GW-1:0]             gap
);

    logic          seen_l, seen_r, both;
    logic [GW-1:0] g_q;
    logic [N_ELEM-1:0] fire;

    assign both = seen_l && seen_r;
    assign gap  = g_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen_l <= 1'b0;
            seen_r <= 1'b0;
            g_q    <= '0;
        end else if (tick && !both) begin
            if (arr_l) seen_l <= 1'b1;
            if (arr_r) seen_r <= 1'b1;
            if (seen_l || seen_r) begin
                if (g_q != '1) g_q <= g_q + GW'(1);
            end else if (arr_l || arr_r) begin
                g_q <= '0;
            end
        end
    end

    for (genvar j = 0; j < N_ELEM; j++) begin : g_elem
        assign fire[j] = both && (g_q <= {{(GW-CW){1'b0}}, win[j]});
    end

    assign hit = (fire[0] && fire[1]) || (fire[0] && fire[2]) || (fire[1] && fire[2]);

    AST_GAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n || clr)
        both |=> $stable(g_q)); // R4

endmodule

// File: rtl/itd_localizer.sv
module itd_localizer
    import itd_pkg::*;
#(
    parameter  int N_CD      = 40,
    parameter  int TICK_DIV  = 50,
    parameter  int DLY_MIN   = 10,
    parameter  int DLY_MAX   = 300,
    parameter  int WIN_TICKS = 300,
    parameter  int CDW_MAX   = 63,
    parameter  int CDW_INIT  = 4,
    localparam int DW        = $clog2(DLY_MAX + 1),
    localparam int CW        = $clog2(CDW_MAX + 1),
    localparam int XW        = (DW > CW) ? DW : CW,
    localparam int IW        = $clog2(N_CD),
    localparam int AW        = (IW < 2) ? 2 : IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spk_l,
    input  logic          spk_r,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_tgt,
    input  logic [AW-1:0] cfg_addr,
    input  logic [XW-1:0] cfg_data,
    output logic          loc_valid,
    output logic [IW-1:0] loc_idx,
    output logic          no_det
);

    localparam int GW = CW + 1;
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam int WW = $clog2(WIN_TICKS + 1);

    // tick prescaler
    logic [PW-1:0] pre_q;
    logic          tick;
    assign tick = (pre_q == PW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= tick ? '0 : pre_q + PW'(1);
    end

    // configuration storage
    logic [N_CD-1:0][DW-1:0]   dly_l, dly_r;
    logic [N_ELEM-1:0][CW-1:0] win;

    itd_cfg_regs #(
        .N(N_CD), .DW(DW), .CW(CW), .XW(XW), .AW(AW),
        .DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX),
        .CDW_MAX(CDW_MAX), .CDW_INIT(CDW_INIT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .tgt(cfg_tgt),
        .addr(cfg_addr), .data(cfg_data),
        .dly_l(dly_l), .dly_r(dly_r), .win(win)
    );

    // control state
    itd_state_e    state_q, state_d;
    logic          pend_l, pend_r, got_l, got_r, found;
    logic [WW-1:0] wcnt;
    logic [IW-1:0] scan_idx, best_idx;
    logic [GW-1:0] best_gap;
    logic          acc_l, acc_r, expire, lines_idle, clr;

    logic [N_CD-1:0]         busy_l, busy_r, emit_l, emit_r, ld_l, ld_r, hit;
    logic [N_CD-1:0][GW-1:0] gap_all;

    assign acc_l = spk_l && ((state_q == ST_IDLE) || (state_q == ST_ARMED && !got_l));
    assign acc_r = spk_r && ((state_q == ST_IDLE) || (state_q == ST_ARMED && !got_r));
    assign expire     = (state_q == ST_ARMED) && tick && (wcnt == WW'(WIN_TICKS - 1));
    assign lines_idle = !(|busy_l) && !(|busy_r);
    assign clr        = (state_q == ST_REPORT);

    // opposed delay chains and coincidence row
    for (genvar k = 0; k < N_CD; k++) begin : g_row
        if (k == 0) begin : g_l_head
            assign ld_l[k] = tick && pend_l;
        end else begin : g_l_body
            assign ld_l[k] = emit_l[k-1];
        end
        if (k == N_CD - 1) begin : g_r_head
            assign ld_r[k] = tick && pend_r;
        end else begin : g_r_body
            assign ld_r[k] = emit_r[k+1];
        end

        itd_tap_stage #(.DW(DW)) u_left (
            .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
            .load(ld_l[k]), .dly(dly_l[k]), .busy(busy_l[k]), .emit(emit_l[k])
        );

        itd_tap_stage #(.DW(DW)) u_right (
            .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
            .load(ld_r[k]), .dly(dly_r[k]), .busy(busy_r[k]), .emit(emit_r[k])
        );

        itd_cd_module #(.CW(CW), .GW(GW)) u_cd (
            .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
            .arr_l(emit_l[k]), .arr_r(emit_r[k]), .win(win),
            .hit(hit[k]), .gap(gap_all[k])
        );
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_l && acc_r)      state_d = ST_TRAVEL;
                else if (acc_l || acc_r) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (acc_l || acc_r) state_d = ST_TRAVEL;
                else if (expire)    state_d = ST_REPORT;
            end
            ST_TRAVEL: begin
                if (lines_idle && !pend_l && !pend_r) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (scan_idx == IW'(N_CD - 1)) state_d = ST_REPORT;
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operation datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l   <= 1'b0;
            pend_r   <= 1'b0;
            got_l    <= 1'b0;
            got_r    <= 1'b0;
            wcnt     <= '0;
            scan_idx <= '0;
            best_idx <= '0;
            best_gap <= '0;
            found    <= 1'b0;
        end else begin
            pend_l <= clr ? 1'b0 : (acc_l ? 1'b1 : (tick ? 1'b0 : pend_l));
            pend_r <= clr ? 1'b0 : (acc_r ? 1'b1 : (tick ? 1'b0 : pend_r));
            got_l  <= clr ? 1'b0 : (got_l || acc_l);
            got_r  <= clr ? 1'b0 : (got_r || acc_r);

            if (state_q == ST_IDLE)            wcnt <= '0;
            else if (state_q == ST_ARMED && tick) wcnt <= wcnt + WW'(1);

            if (state_q == ST_IDLE) begin
                scan_idx <= '0;
                found    <= 1'b0;
            end else if (state_q == ST_SCAN) begin
                scan_idx <= scan_idx + IW'(1);
                if (hit[scan_idx] && (!found || gap_all[scan_idx] < best_gap)) begin
                    found    <= 1'b1;
                    best_idx <= scan_idx;
                    best_gap <= gap_all[scan_idx];
                end
            end
        end
    end

    // outputs
    always_comb begin
        loc_valid = (state_q == ST_REPORT) && found;
        no_det    = (state_q == ST_REPORT) && !found;
        loc_idx   = loc_valid ? best_idx : '0;
    end

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid || no_det) |=> !(loc_valid || no_det)); // R9
    AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid |-> (loc_idx <= IW'(N_CD - 1))); // R6
    AST_IDLE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> lines_idle); // R2
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> (wcnt < WW'(WIN_TICKS))); // R7
    AST_VALID_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid |-> hit[loc_idx]); // R8

endmodule

// File: tb/tb_itd_localizer.sv
module tb_itd_localizer;

    localparam int N    = 8;
    localparam int DIV  = 2;
    localparam int DMIN = 2;
    localparam int DMAX = 12;
    localparam int WIN  = 12;
    localparam int CMAX = 15;
    localparam int CINI = 1;
    localparam int AW   = 3;
    localparam int XW   = 4;
    localparam int IW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spk_l = 1'b0, spk_r = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_tgt = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [XW-1:0] cfg_data = '0;
    logic          loc_valid, no_det;
    logic [IW-1:0] loc_idx;

    int total = 0;
    int bad = 0;
    int m_dl[N];
    int m_dr[N];
    int m_w[3];

    always #10 clk = ~clk;

    itd_localizer #(
        .N_CD(N), .TICK_DIV(DIV), .DLY_MIN(DMIN), .DLY_MAX(DMAX),
        .WIN_TICKS(WIN), .CDW_MAX(CMAX), .CDW_INIT(CINI)
    ) dut (
        .clk(clk), .rst_n(rst_n), .spk_l(spk_l), .spk_r(spk_r),
        .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .loc_valid(loc_valid), .loc_idx(loc_idx), .no_det(no_det)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int imin(input int a, input int b); return (a < b) ? a : b; endfunction
    function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction

    // expected winner; -1 means no detection (R2, R4, R5, R6, R8)
    function automatic int model_idx(input int itd);
        int med, best, bg;
        med  = imax(imin(m_w[0], m_w[1]), imin(imax(m_w[0], m_w[1]), m_w[2]));
        best = -1;
        bg   = 0;
        for (int i = 0; i < N; i++) begin
            int al, ar, g;
            al = 0;
            ar = itd;
            for (int k = 0; k <= i; k++) al += m_dl[k];
            for (int k = i; k < N; k++)  ar += m_dr[k];
            g = (al > ar) ? al - ar : ar - al;
            if (g <= med && (best < 0 || g < bg)) begin
                best = i;
                bg   = g;
            end
        end
        return best;
    endfunction

    task automatic cfg_write(input int tgt, input int addr, input int data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_tgt  = 2'(tgt);
        cfg_addr = AW'(addr);
        cfg_data = XW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (tgt == 0 && addr < N) m_dl[addr] = clampi(data, DMIN, DMAX);
        if (tgt == 1 && addr < N) m_dr[addr] = clampi(data, DMIN, DMAX);
        if (tgt == 2 && addr < 3) m_w[addr]  = clampi(data, 0, CMAX);
    endtask

    task automatic set_uniform(input int d);
        for (int k = 0; k < N; k++) begin
            cfg_write(0, k, d);
            cfg_write(1, k, d);
        end
    endtask

    task automatic set_wins(input int a, input int b, input int c);
        cfg_write(2, 0, a);
        cfg_write(2, 1, b);
        cfg_write(2, 2, c);
    endtask

    task automatic wait_result(output int act);
        int n;
        n = 0;
        while (!(loc_valid || no_det) && n < 4000) begin
            @(negedge clk);
            n++;
        end
        act = loc_valid ? int'(loc_idx) : (no_det ? -1 : -2);
    endtask

    // one spike pair; itd > 0 means right after left, in ticks
    task automatic do_op(input int itd, input bit extra, input string req);
        int k, expv, act;
        bit first_l, ok;
        k       = (itd < 0) ? -itd : itd;
        first_l = (itd >= 0);
        expv    = model_idx(itd);
        @(negedge clk);
        if (itd == 0) begin
            spk_l = 1'b1;
            spk_r = 1'b1;
        end else if (first_l) spk_l = 1'b1;
        else                  spk_r = 1'b1;
        for (int c = 1; c <= k * DIV; c++) begin
            @(negedge clk);
            spk_l = 1'b0;
            spk_r = 1'b0;
            if (extra && c == 2 && c < k * DIV) begin
                if (first_l) spk_l = 1'b1;
                else         spk_r = 1'b1;
            end
            if (c == k * DIV) begin
                if (first_l) spk_r = 1'b1;
                else         spk_l = 1'b1;
            end
        end
        @(negedge clk);
        spk_l = 1'b0;
        spk_r = 1'b0;
        if (extra) begin
            repeat (2) @(negedge clk);
            spk_l = 1'b1;
            spk_r = 1'b1;
            @(negedge clk);
            spk_l = 1'b0;
            spk_r = 1'b0;
        end
        wait_result(act);
        ok = (expv < 0) ? (no_det && !loc_valid) : (loc_valid && !no_det && int'(loc_idx) == expv);
        check(ok, req, act, expv);
        @(negedge clk);
        check(!loc_valid && !no_det, "R9 single pulse", int'(loc_valid | no_det), 0);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog all act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int act, n;
        void'($urandom(32'd4242));
        for (int k = 0; k < N; k++) begin
            m_dl[k] = DMIN;
            m_dr[k] = DMIN;
        end
        for (int j = 0; j < 3; j++) m_w[j] = CINI;

        repeat (4) @(negedge clk);
        check(!loc_valid && !no_det && loc_idx == '0, "R1 reset outputs", int'(loc_valid | no_det), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(!loc_valid && !no_det, "R1 quiet idle", int'(loc_valid | no_det), 0);

        // uniform taps of 2: gap_i = |itd + 14 - 4i|
        set_wins(4, 4, 4);
        do_op(0, 1'b0, "R11 simultaneous spikes, R6 tie lowest");   // gaps 2 at i=3,4 -> 3
        check(model_idx(0) == 3, "R6 model tie", model_idx(0), 3);
        do_op(-1, 1'b0, "R4 right first");                        // -> 3
        do_op(1, 1'b0, "R4 left first");                          // -> 4
        do_op(6, 1'b0, "R2 shifted coincidence");
        set_wins(0, 0, 15);
        do_op(1, 1'b0, "R5 one element only");                    // median 0 -> no det
        set_wins(0, 1, 1);
        do_op(1, 1'b0, "R5 two elements agree");                  // -> 4
        cfg_write(3, 0, 15);
        cfg_write(2, 5, 0);
        do_op(1, 1'b0, "R12 ignored writes");                     // still 4
        set_wins(0, 0, 0);
        do_op(3, 1'b0, "R8 no module hit");                       // odd gaps -> no det
        do_op(2, 1'b0, "R4 exact coincidence");                   // -> 4
        cfg_write(0, 0, 1);                                       // clamps to 2
        do_op(2, 1'b0, "R3 low clamp");                           // -> 4
        cfg_write(1, 7, 15);                                      // clamps to 12
        check(m_dr[7] == DMAX, "R3 model high clamp", m_dr[7], DMAX);
        do_op(-8, 1'b0, "R3 high clamp");
        set_uniform(2);
        set_wins(3, 3, 3);
        do_op(5, 1'b1, "R10 extra spikes ignored");
        do_op(WIN - 1, 1'b0, "R7 last accepted offset");
        do_op(-(WIN - 1), 1'b1, "R7 last accepted offset, R10");

        // single spike: window expires
        @(negedge clk);
        spk_r = 1'b1;
        @(negedge clk);
        spk_r = 1'b0;
        n = 1;
        while (!(loc_valid || no_det) && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(no_det && !loc_valid, "R7 single spike no detection", int'(no_det), 1);
        check(n >= (WIN - 1) * DIV && n <= WIN * DIV + 2, "R7 window length", n, WIN * DIV);
        @(negedge clk);
        check(!loc_valid && !no_det, "R9 single pulse after timeout", int'(no_det), 0);

        // constrained random operations
        for (int it = 0; it < 40; it++) begin
            for (int r = 0; r < 3; r++) begin
                cfg_write(int'($urandom_range(1, 0)), int'($urandom_range(N - 1, 0)),
                          int'($urandom_range(15, 0)));
            end
            if ((it % 4) == 0) begin
                set_wins(int'($urandom_range(CMAX, 0)), int'($urandom_range(CMAX, 0)),
                         int'($urandom_range(CMAX, 0)));
            end
            do_op(int'($urandom_range(2 * (WIN - 1), 0)) - (WIN - 1), 1'($urandom_range(1, 0)),
                  "R2 R5 R6 random pair");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule